// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a byte-wide serial EEPROM that answers as a target on a two-wire (I2C) bus. A fast system clock oversamples SCL and SDA. The block finds START and STOP conditions and shifts bytes in on rising SCL edges. It drives SDA through an open-drain output enable, changing it only after a falling SCL edge. Two strap inputs set the low bits of its bus address, so four of these blocks can share one bus.

A host writes by sending the address byte, a high and a low word-address byte, then one or more data bytes. The data bytes collect in a one-page buffer and reach the array only after STOP. They are committed during a self-timed busy period, and the block ignores its address for the whole of that period. A host reads by sending the address byte with the read bit set, either directly or after a dummy write that loads the word address. The address advances after every byte sent. A write-protect input, sampled at STOP, blocks the commit of the whole array.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the output enable `sda_oe_o` is low and the block waits for a START.
- R2: The address byte has the form 1010_0_S1_S0_RW, sent MSB first. The block acknowledges it only when bits 2:1 equal `strap_i[1:0]`. For any other value it leaves SDA released in the ninth clock and ignores the bus until the next START.
- R3: For every byte it accepts while being written (address, high address, low address, data), the block pulls SDA low through the whole ninth SCL period.
- R4: The word address is sent high byte first. Address bits at or above log2(MEM_DEPTH) are ignored. A byte write followed by a dummy write, a repeated START and a read returns the written byte.
- R5: One write transfer accepts any number of data bytes, up to 128, and each lands at its own address once the transfer has ended with STOP.
- R6: During a write the low 7 address bits advance after each data byte and wrap from 127 to 0. The upper bits stay the same, so the data stays inside one 128-byte page.
- R7: A STOP that ends a write with at least one data byte starts a busy period of TWR_CYCLES clocks. During that period the address byte is not acknowledged. It is acknowledged again afterwards.
- R8: If `wp_i` is high at the STOP, the buffered bytes are dropped, the array keeps its old contents, and no busy period follows.
- R9: In a read the address advances after each byte. It rolls from MEM_DEPTH-1 to 0. The read ends when the host answers a byte with NACK.
- R10: A read that starts without a preceding dummy write begins at the address that follows the last byte read.
- R11: A repeated START drops any data bytes buffered so far in the transfer, so the STOP that follows writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | 2 | Address strap bits, compared with address bits 2:1 |
| wp_i | input | 1 | High blocks the array from being written |

## Verification
The assertions assume that SDA from the host changes only while SCL is low, except for START and STOP. They also assume that every SCL and SDA level lasts at least three system clocks, so that the synchronizer sees each edge in the right order. The bench drives the bus in quarter-bit steps of three clocks on the falling system edge. It changes data one quarter after SCL falls and samples one quarter after SCL rises. It holds `wp_i` and the straps steady around every STOP and address byte.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    localparam logic [4:0] DEV_PREFIX = 5'b10100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_ACK,
        ST_RD,
        ST_RACK
    } state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_s
);
    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.scl = {r_q.scl[1:0], scl_i};
        r_d.sda = {r_q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    assign scl_rise = r_q.scl[1] & ~r_q.scl[2];
    assign scl_fall = ~r_q.scl[1] & r_q.scl[2];
    assign start_ev = r_q.scl[1] & r_q.scl[2] & r_q.sda[2] & ~r_q.sda[1];
    assign stop_ev  = r_q.scl[1] & r_q.scl[2] & ~r_q.sda[2] & r_q.sda[1];
    assign sda_s    = r_q.sda[1];
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int MEM_DEPTH = 1024,
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_write_engine.sv
module eeprom_write_engine #(
    parameter int MEM_DEPTH  = 1024,
    parameter int PAGE_BYTES = 128,
    parameter int TWR_CYCLES = 400,
    localparam int AW = $clog2(MEM_DEPTH),
    localparam int PW = $clog2(PAGE_BYTES),
    localparam int CW = $clog2(TWR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_we,
    input  logic [PW-1:0] buf_idx,
    input  logic [AW-PW-1:0] buf_page,
    input  logic [7:0]    buf_data,
    input  logic          clr_req,
    input  logic          stop_req,
    input  logic          wp_i,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wd
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      mask;
        logic [AW-PW-1:0]           page;
        logic                       busy;
        logic [CW-1:0]              cnt;
    } eng_t;

    eng_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        if (r_q.busy) begin
            r_d.cnt = r_q.cnt + 1'b1;
            if (r_q.cnt < CW'(PAGE_BYTES) && r_q.mask[r_q.cnt[PW-1:0]]) mem_we = 1'b1;
            if (r_q.cnt == CW'(TWR_CYCLES - 1)) begin
                r_d.busy = 1'b0;
                r_d.mask = '0;
            end
        end else begin
            if (clr_req) r_d.mask = '0;
            if (buf_we) begin
                r_d.data[buf_idx] = buf_data;
                r_d.mask[buf_idx] = 1'b1;
                r_d.page          = buf_page;
            end
            if (stop_req) begin
                if (|r_q.mask && !wp_i) begin
                    r_d.busy = 1'b1;
                    r_d.cnt  = '0;
                end else begin
                    r_d.mask = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = r_q.busy;
    assign mem_addr = {r_q.page, r_q.cnt[PW-1:0]};
    assign mem_wd   = r_q.data[r_q.cnt[PW-1:0]];

    AST_NO_COMMIT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.busy) |-> !$past(wp_i)) else $error("commit under write protect"); // R8
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_eeprom_pkg::*;
#(
    parameter int MEM_DEPTH  = 1024,
    parameter int PAGE_BYTES = 128,
    parameter int TWR_CYCLES = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] strap_i,
    input  logic       wp_i
);
    localparam int AW = $clog2(MEM_DEPTH);
    localparam int PW = $clog2(PAGE_BYTES);

    typedef struct packed {
        state_e        state;
        state_e        nxt;
        logic [3:0]    bitcnt;
        logic [7:0]    sh;
        logic [7:0]    tx;
        logic [7:0]    ahi;
        logic [AW-1:0] addr;
        logic          oe;
        logic          mack;
    } ctl_t;

    ctl_t r_q, r_d;

    logic scl_rise, scl_fall, start_ev, stop_ev, sda_s;
    logic busy, mem_we, buf_we, stop_req, clr_req;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wd, rd_data;
    logic [15:0] addr16;

    i2c_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s)
    );

    eeprom_write_engine #(
        .MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES), .TWR_CYCLES(TWR_CYCLES)
    ) u_weng (
        .clk(clk), .rst_n(rst_n),
        .buf_we(buf_we), .buf_idx(r_q.addr[PW-1:0]), .buf_page(r_q.addr[AW-1:PW]),
        .buf_data(r_q.sh), .clr_req(clr_req), .stop_req(stop_req), .wp_i(wp_i),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wd(mem_wd)
    );

    eeprom_array #(.MEM_DEPTH(MEM_DEPTH)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wd),
        .raddr(r_q.addr), .rdata(rd_data)
    );

    always_comb begin
        r_d      = r_q;
        buf_we   = 1'b0;
        stop_req = 1'b0;
        clr_req  = 1'b0;
        addr16   = {r_q.ahi, r_q.sh};
        if (start_ev) begin
            r_d.state  = ST_DEV;
            r_d.bitcnt = '0;
            r_d.oe     = 1'b0;
            clr_req    = 1'b1;
        end else if (stop_ev) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
            stop_req  = 1'b1;
        end else begin
            case (r_q.state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && r_q.bitcnt != 4'd8) begin
                        r_d.sh     = {r_q.sh[6:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (scl_fall && r_q.bitcnt == 4'd8) begin
                        r_d.bitcnt = '0;
                        r_d.state  = ST_ACK;
                        r_d.oe     = 1'b1;
                        case (r_q.state)
                            ST_DEV: begin
                                if (r_q.sh[7:3] == DEV_PREFIX && r_q.sh[2:1] == strap_i && !busy) begin
                                    r_d.nxt = r_q.sh[0] ? ST_RD : ST_AHI;
                                end else begin
                                    r_d.state = ST_IDLE;
                                    r_d.oe    = 1'b0;
                                end
                            end
                            ST_AHI: begin
                                r_d.ahi = r_q.sh;
                                r_d.nxt = ST_ALO;
                            end
                            ST_ALO: begin
                                r_d.addr = addr16[AW-1:0];
                                r_d.nxt  = ST_WDAT;
                            end
                            default: begin
                                buf_we = 1'b1;
                                r_d.addr[PW-1:0] = r_q.addr[PW-1:0] + 1'b1;
                                r_d.nxt = ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.oe    = 1'b0;
                        r_d.state = r_q.nxt;
                        if (r_q.nxt == ST_RD) begin
                            r_d.tx = rd_data;
                            r_d.oe = ~rd_data[7];
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (scl_fall && r_q.bitcnt == 4'd8) begin
                        r_d.oe     = 1'b0;
                        r_d.state  = ST_RACK;
                        r_d.bitcnt = '0;
                        r_d.addr   = r_q.addr + 1'b1;
                    end else if (scl_fall && r_q.bitcnt != 4'd0) begin
                        r_d.tx = {r_q.tx[6:0], 1'b0};
                        r_d.oe = ~r_q.tx[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack   = ~sda_s;
                        r_d.bitcnt = 4'd1;
                    end else if (scl_fall && r_q.bitcnt == 4'd1) begin
                        r_d.bitcnt = '0;
                        if (r_q.mack) begin
                            r_d.tx    = rd_data;
                            r_d.oe    = ~rd_data[7];
                            r_d.state = ST_RD;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.nxt   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;

    AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall | start_ev | stop_ev)) else $error("SDA driven off a falling edge"); // R3
    AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && r_q.state == ST_DEV && r_q.bitcnt == 4'd8 && busy && !start_ev && !stop_ev)
        |=> !sda_oe_o) else $error("address acknowledged while busy"); // R7
    AST_STRAP_MISMATCH_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && r_q.state == ST_DEV && r_q.bitcnt == 4'd8 && r_q.sh[2:1] != strap_i && !start_ev && !stop_ev)
        |=> !sda_oe_o) else $error("foreign address acknowledged"); // R2
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> $stable(r_q.addr[AW-1:PW])) else $error("write left its page"); // R6
endmodule

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
    localparam int DEPTH = 256;
    localparam int TWR   = 200;
    localparam int Q     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'd0;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    logic [7:0] expm [DEPTH];
    logic [7:0] rbuf [256];
    logic [7:0] wbuf [128];

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_eeprom_target #(.MEM_DEPTH(DEPTH), .PAGE_BYTES(128), .TWR_CYCLES(TWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic d, output logic s);
        sda_m = d; qw();
        scl_m = 1'b1; qw();
        s = sda_bus; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw(); qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b1, s);
            b = {b[6:0], s};
        end
        bit_xfer(~give_ack, s);
    endtask

    task automatic poll(output int nacks);
        logic ack;
        nacks = 0;
        for (int k = 0; k < 100; k++) begin
            bus_start();
            send_byte(8'hA2, ack);
            bus_stop();
            if (ack) break;
            nacks++;
        end
    endtask

    // write n bytes of wbuf starting at a; acks checked (R3)
    task automatic write_at(input logic [15:0] a, input int n);
        logic ack;
        bus_start();
        send_byte(8'hA2, ack); chk(ack, "R3 addr ack", ack, 1);
        send_byte(a[15:8], ack); chk(ack, "R3 hi ack", ack, 1);
        send_byte(a[7:0], ack);  chk(ack, "R3 lo ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            if (!ack) chk(ack, "R3 data ack", ack, 1);
        end
        bus_stop();
    endtask

    task automatic read_at(input logic [15:0] a, input int n);
        logic ack;
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(8'hA3, ack);
        chk(ack, "R4 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        int nk;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);

        // R2: every strap against every sent strap field
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int a = 0; a < 4; a++) begin
                bus_start();
                send_byte(8'hA0 | 8'(a << 1), ack);
                bus_stop();
                chk(ack == (a == s), "R2 strap match", ack, (a == s));
            end
        end
        strap = 2'd1;
        bus_start(); send_byte(8'hB2, ack); bus_stop();
        chk(!ack, "R2 wrong prefix", ack, 0);

        // R5: fill both pages, upper address byte set to junk (R4)
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 128; i++) begin
                wbuf[i] = 8'((p * 128 + i) * 7 + 3);
                expm[p * 128 + i] = wbuf[i];
            end
            write_at({8'h5A, 8'(p * 128)}, 128);
            poll(nk);
            chk(nk >= 1, "R7 busy nack after stop", nk, 1);
        end
        read_at(16'h0000, 256);
        for (int i = 0; i < 256; i++)
            chk(rbuf[i] == expm[i], "R5 page data", rbuf[i], expm[i]);

        // R9 rollover
        read_at(16'h00FE, 4);
        for (int i = 0; i < 4; i++)
            chk(rbuf[i] == expm[(254 + i) % 256], "R9 rollover", rbuf[i], expm[(254 + i) % 256]);

        // R10 current address continues at 2
        bus_start(); send_byte(8'hA3, ack); recv_byte(1'b0, rbuf[0]); bus_stop();
        chk(rbuf[0] == expm[2], "R10 current addr", rbuf[0], expm[2]);

        // R6 wrap in page 1 from offset 126
        for (int i = 0; i < 5; i++) begin
            wbuf[i] = 8'hC0 + 8'(i);
            expm[128 + (126 + i) % 128] = wbuf[i];
        end
        write_at(16'h00FE, 5);
        poll(nk);
        read_at(16'h0080, 128);
        for (int i = 0; i < 128; i++)
            chk(rbuf[i] == expm[128 + i], "R6 page wrap", rbuf[i], expm[128 + i]);

        // R4 byte write and random read
        wbuf[0] = 8'h3C; expm[16] = 8'h3C;
        write_at(16'h0010, 1);
        poll(nk);
        chk(nk >= 1, "R7 busy after byte write", nk, 1);
        read_at(16'h0010, 1);
        chk(rbuf[0] == 8'h3C, "R4 random read", rbuf[0], 8'h3C);

        // R8 write protect
        wp = 1'b1;
        wbuf[0] = ~expm[32];
        write_at(16'h0020, 1);
        bus_start(); send_byte(8'hA2, ack); bus_stop();
        wp = 1'b0;
        chk(ack, "R8 no busy when protected", ack, 1);
        read_at(16'h0020, 1);
        chk(rbuf[0] == expm[32], "R8 array unchanged", rbuf[0], expm[32]);

        // R11 repeated START drops buffered data
        bus_start();
        send_byte(8'hA2, ack); send_byte(8'h00, ack); send_byte(8'h30, ack);
        send_byte(~expm[48], ack);
        bus_start(); send_byte(8'hA3, ack); recv_byte(1'b0, rbuf[0]); bus_stop();
        chk(rbuf[0] == expm[49], "R11 read after restart", rbuf[0], expm[49]);
        bus_start(); send_byte(8'hA2, ack); bus_stop();
        chk(ack, "R11 no busy", ack, 1);
        read_at(16'h0030, 1);
        chk(rbuf[0] == expm[48], "R11 data dropped", rbuf[0], expm[48]);
        chk(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule